// File: doc/BRIEF.md
# Buffered Saturating Receive Error Counter Bank

This block keeps five independent tallies of receive-side error events: line code violations, framing bit errors, CRC6 errors, errored blocks and PRBS bit errors. The detection logic outside the block delivers one single-cycle strobe per kind, on the receive clock. Each tally is 16 bits wide and stops at all ones instead of wrapping.

Software never reads a live tally. Every tally has a snapshot register, and software sees only that register. A transfer copies each live tally into its snapshot and restarts the tally in the same edge. The mode input chooses what starts a transfer. In periodic mode the one-second tick starts it. In on-demand mode, software writes a request bit. That bit stays set until the copy is done and then clears itself, so software can poll it for completion. An event that lands on the transfer edge is never lost: it becomes the first count of the new period.

Top module: `err_tally_bank`

## Requirements
- R1: While reset is asserted and at the first cycle after it, every snapshot field reads 0 and `req_pend_o` is 0.
- R2: Each strobe bit k of `evt_i` adds exactly one to tally k only. Bit order is 0 code violation, 1 framing bit, 2 CRC6, 3 errored block, 4 PRBS. Snapshot k sits in `snap_o[16k+15:16k]`. The strobes are not visible at `snap_o` until a transfer.
- R3: A tally that has reached 0xFFFF stays at 0xFFFF when further strobes arrive. It never wraps.
- R4: With `demand_mode_i` = 0, a cycle with `sec_tick_i` = 1 copies every tally into its snapshot at that clock edge and restarts every tally.
- R5: When strobe k is high in a transfer cycle, snapshot k receives the count from before that strobe, and tally k restarts at 1.
- R6: Without a transfer, every snapshot field holds its value.
- R7: With `demand_mode_i` = 1, a cycle with `req_wr_i` = 1 sets `req_pend_o` at that edge. At the following edge the transfer takes place and `req_pend_o` returns to 0.
- R8: With `demand_mode_i` = 1, `sec_tick_i` has no effect. With `demand_mode_i` = 0, `req_wr_i` has no effect and `req_pend_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 5 | One error strobe per kind, bit k feeds tally k |
| sec_tick_i | input | 1 | One-second tick, used only in periodic mode |
| demand_mode_i | input | 1 | 0 periodic transfer, 1 on-demand transfer |
| req_wr_i | input | 1 | Software write of the latch request bit |
| req_pend_o | output | 1 | Request pending; falls when the on-demand transfer is done |
| snap_o | output | 80 | Five 16-bit snapshots, kind k in bits 16k+15:16k |

## Verification
The assertions are checked on every cycle. They cover these properties:
- a saturated tally holds at all ones;
- a colliding strobe restarts its tally at one;
- each snapshot takes the pre-transfer tally;
- snapshots stay still when no transfer occurs;
- the request bit clears one edge after it is seen, and never rises in periodic mode.

The bench scenarios cover what a single-cycle property cannot show. They compare exact end-of-period counts under all 32 strobe combinations and check that kinds stay separate. They run a full climb to saturation across more than 65,536 strobes, and check the cycle-exact order of the on-demand handshake.

// File: rtl/err_tally_pkg.sv
package err_tally_pkg;

    localparam int unsigned TALLY_W_DEF = 16;
    localparam int unsigned KINDS_DEF   = 5;

    typedef enum logic [2:0] {
        KIND_LINE_CODE = 3'd0,
        KIND_FRAME_BIT = 3'd1,
        KIND_CRC6      = 3'd2,
        KIND_BLOCK     = 3'd3,
        KIND_PRBS      = 3'd4
    } err_kind_e;

    typedef struct packed {
        logic pend;
    } ctrl_state_t;

endpackage

// File: rtl/err_tally_ctrl.sv
module err_tally_ctrl
    import err_tally_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick_i,
    input  logic demand_mode_i,
    input  logic req_wr_i,
    output logic xfer_o,
    output logic pend_o
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // transfer source depends on mode
        xfer_o = demand_mode_i ? st_q.pend : sec_tick_i;
        if (!demand_mode_i) begin
            st_d.pend = 1'b0;
        end else if (st_q.pend) begin
            st_d.pend = 1'b0;       // transfer happens this edge
        end else begin
            st_d.pend = req_wr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/err_tally_cell.sv
module err_tally_cell #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic         xfer_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] snap_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] snap;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xfer_i) begin
            st_d.snap = st_q.cnt;
            st_d.cnt  = evt_i ? CNT_ONE : '0;   // colliding strobe kept
        end else if (evt_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign snap_o = st_q.snap;

endmodule

// File: rtl/err_tally_bank.sv
module err_tally_bank
    import err_tally_pkg::*;
#(
    parameter int unsigned N_KINDS = KINDS_DEF,
    parameter int unsigned CNT_W   = TALLY_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_KINDS-1:0]         evt_i,
    input  logic                       sec_tick_i,
    input  logic                       demand_mode_i,
    input  logic                       req_wr_i,
    output logic                       req_pend_o,
    output logic [N_KINDS*CNT_W-1:0]   snap_o
);

    localparam int unsigned BUS_W = N_KINDS * CNT_W;

    logic             xfer;
    logic [BUS_W-1:0] cnt_flat;

    err_tally_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_tick_i   (sec_tick_i),
        .demand_mode_i(demand_mode_i),
        .req_wr_i     (req_wr_i),
        .xfer_o       (xfer),
        .pend_o       (req_pend_o)
    );

    for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
        err_tally_cell #(.W(CNT_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_i[k]),
            .xfer_i(xfer),
            .cnt_o (cnt_flat[k*CNT_W +: CNT_W]),
            .snap_o(snap_o[k*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/err_tally_chk.sv
module err_tally_chk #(
    parameter int unsigned N = 5,
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] evt_i,
    input logic         sec_tick_i,
    input logic         demand_mode_i,
    input logic         req_wr_i,
    input logic         req_pend_o,
    input logic [N*W-1:0] snap_o,
    input logic [N*W-1:0] cnt_flat
);

    logic xfer_seen;
    assign xfer_seen = demand_mode_i ? req_pend_o : sec_tick_i;

    // R7: a pending request is served at the next edge
    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (demand_mode_i && req_pend_o) |=> !req_pend_o);

    // R8: no request can rise in periodic mode
    p_mode_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!demand_mode_i) |=> !req_pend_o);

    // R6: snapshots still without a transfer
    p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_seen) |=> $stable(snap_o));

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R3: saturated tally stays at all ones
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_flat[k*W +: W] == {W{1'b1}}) && !xfer_seen) |=> (cnt_flat[k*W +: W] == {W{1'b1}}));

        // R5: colliding strobe starts the new period at one
        p_restart_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_seen && evt_i[k]) |=> (cnt_flat[k*W +: W] == {{(W-1){1'b0}}, 1'b1}));

        // R4: snapshot takes the pre-transfer tally
        p_snap_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_seen |=> (snap_o[k*W +: W] == $past(cnt_flat[k*W +: W])));
    end

endmodule

bind err_tally_bank err_tally_chk #(.N(N_KINDS), .W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .sec_tick_i   (sec_tick_i),
    .demand_mode_i(demand_mode_i),
    .req_wr_i     (req_wr_i),
    .req_pend_o   (req_pend_o),
    .snap_o       (snap_o),
    .cnt_flat     (cnt_flat)
);

// File: tb/err_tally_bank_bench.sv
module err_tally_bank_bench;

    localparam int N = 5;
    localparam int W = 16;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         sec_tick_i = 1'b0;
    logic         demand_mode_i = 1'b0;
    logic         req_wr_i = 1'b0;
    logic         req_pend_o;
    logic [N*W-1:0] snap_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int m_cnt  [N];
    int m_snap [N];
    bit m_pend = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    err_tally_bank u_err_tally_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .sec_tick_i   (sec_tick_i),
        .demand_mode_i(demand_mode_i),
        .req_wr_i     (req_wr_i),
        .req_pend_o   (req_pend_o),
        .snap_o       (snap_o)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check_all(input string tag);
        for (int k = 0; k < N; k++) begin
            checks++;
            if (int'(snap_o[k*W +: W]) != m_snap[k]) begin
                errors++;
                $display("FAIL %s snap kind %0d actual %h expected %h", tag, k,
                         snap_o[k*W +: W], m_snap[k]);
            end
        end
        checks++;
        if (req_pend_o != m_pend) begin
            errors++;
            $display("FAIL %s req_pend actual %0b expected %0b", tag, req_pend_o, m_pend);
        end
    endtask

    // one clock: drive at negedge, update model, sample 1 ns after posedge
    task automatic step(input logic [N-1:0] ev, input logic tick, input logic wr);
        bit xf;
        @(negedge clk);
        evt_i = ev; sec_tick_i = tick; req_wr_i = wr;
        xf = demand_mode_i ? m_pend : tick;
        for (int k = 0; k < N; k++) begin
            if (xf) begin
                m_snap[k] = m_cnt[k];
                m_cnt[k]  = ev[k] ? 1 : 0;
            end else if (ev[k] && m_cnt[k] < MAXV) begin
                m_cnt[k]++;
            end
        end
        if (!demand_mode_i) m_pend = 1'b0;
        else if (m_pend)    m_pend = 1'b0;
        else                m_pend = wr;
        @(posedge clk);
        #1;
        evt_i = '0; sec_tick_i = 1'b0; req_wr_i = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin m_cnt[k] = 0; m_snap[k] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");            // during reset
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1");

        // R2/R6: all strobe combinations, snapshots must not move
        for (int p = 0; p < 32; p++) begin
            for (int r = 0; r <= p % 4; r++) begin
                step(p[N-1:0], 1'b0, 1'b0);
                check_all("R6");
            end
        end
        // R2/R4: tick publishes the per-kind totals
        step('0, 1'b1, 1'b0);
        check_all("R4");
        step('0, 1'b1, 1'b0);       // empty period publishes zeros
        check_all("R2");

        // R5: collision of every pattern with the tick
        for (int p = 0; p < 32; p++) begin
            step(5'b00101 ^ p[N-1:0], 1'b0, 1'b0);
            step(p[N-1:0], 1'b1, 1'b0);
            check_all("R5");
        end
        step('0, 1'b1, 1'b0);
        check_all("R5");

        // R8: request writes ignored in periodic mode
        step(5'b11000, 1'b0, 1'b1);
        check_all("R8");
        step('0, 1'b0, 1'b1);
        check_all("R8");

        // R7: on-demand handshake
        @(negedge clk); demand_mode_i = 1'b1;
        step(5'b00011, 1'b0, 1'b0);
        step(5'b10000, 1'b1, 1'b0);  // R8: tick ignored
        check_all("R8");
        step(5'b01010, 1'b0, 1'b1);
        check_all("R7");             // pending, snapshots old
        step(5'b00001, 1'b0, 1'b1);  // transfer with collision
        check_all("R7");
        step('0, 1'b0, 1'b0);
        check_all("R7");
        step('0, 1'b0, 1'b1);
        step('0, 1'b0, 1'b0);
        check_all("R7");

        // R3: climb past the top in on-demand mode
        for (int i = 0; i < MAXV + 300; i++) begin
            step((i % 3 == 0) ? 5'b11111 : 5'b10101, 1'b0, 1'b0);
            if (i % 4096 == 0) check_all("R6");
        end
        step('0, 1'b0, 1'b1);
        step('0, 1'b0, 1'b0);
        check_all("R3");
        step('0, 1'b0, 1'b1);
        step(5'b00100, 1'b0, 1'b0);
        check_all("R3");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual %0d cycles expected completion", cycles);
                summary();
                $finish;
            end
        end
    end

endmodule